// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the raster timing for a simple LCD panel. Software writes three packed timing words and a control word over a plain register bus. The block derives a pixel-clock enable from a programmable divider of the system clock and walks a pixel counter and a line counter through each frame. From those counters it decodes horizontal sync, vertical sync and a data-enable window. Inside the active window it also reports the current pixel column and line row.

Each frame starts with the vertical sync lines. After them come the vertical back porch, the active lines and the vertical front porch. Each line follows the same pattern: the hsync pulse, the back porch, the active pixels, then the front porch. The horizontal fields hold their value minus one. The vertical porches hold true line counts.

Clearing the enable bit never truncates the picture. The current frame finishes, then the outputs go idle and a DONE status bit is raised. The same write drops every interrupt mask except the one for DONE. A level interrupt combines the status bits with their masks.

Top module: `lcd_raster_timer`

## Requirements
- R1: After reset all registers read zero, sync and data-enable outputs are at their inactive level (low), and the interrupt is low.
- R2: Horizontal word (address 1): active pixels minus one in bits 9:0, sync width minus one in 15:10, front porch minus one in 23:16, back porch minus one in 31:24. Each line is hsync, back porch, active, front porch, and data-enable is never asserted with hsync.
- R3: Vertical word (address 2): active lines minus one in 9:0, sync width minus one in 15:10, front porch line count in 23:16, back porch line count in 31:24. Each frame is vsync, back porch, active, front porch, and data-enable is never asserted with vsync.
- R4: Clock word (address 3) bits 7:0 set the divider. The pixel enable pulses once every divider system clocks. A value below 2 in TFT mode, or below 3 in passive mode, acts as that minimum.
- R5: When the enable bit (control bit 0) is cleared during a frame, that frame completes. At its final pixel tick the outputs go idle and status bit 0 (DONE) is set.
- R6: A control write that clears the enable bit while it was set also clears the frame-start mask (control bit 9) whatever is written there. The DONE mask (control bit 8) takes the written value.
- R7: The enable bit is looked at only at a frame boundary. Clearing and then setting it again within one frame changes nothing. A start from idle begins on the first line and first pixel of vsync.
- R8: Clock word bit 20 inverts vsync and bit 21 inverts hsync, both while running and while idle. Bits 25:20, 15:8 and 7:0 of that word read back.
- R9: The status register (address 4) is write-one-to-clear. The interrupt is the OR of status bits whose masks are set. A set event wins over a clear in the same cycle.
- R10: Status bit 1 is set at the start of every frame.
- R11: During data-enable, the pixel output counts 0 up to the active pixel count minus one along the line, and the line output counts 0 up to the active line count minus one.
- R12: Control bit 1 selects TFT (1) or passive (0) mode and is reflected on the mode output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write register address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Read register address |
| rd_data_o | output | 32 | Read data (combinational) |
| pclk_en_o | output | 1 | Pixel clock enable, one system clock wide |
| hsync_o | output | 1 | Horizontal sync, polarity per R8 |
| vsync_o | output | 1 | Vertical sync, polarity per R8 |
| de_o | output | 1 | Data enable (active pixel window) |
| pixel_x_o | output | 10 | Column inside the active window |
| line_y_o | output | 10 | Row inside the active window |
| tft_o | output | 1 | Panel mode select, 1 = TFT |
| irq_o | output | 1 | Level interrupt |

## Verification
The end of a stopping frame raises DONE, and software may write a one to clear DONE in that very same clock. The bench locks to the rising edge of vsync of a frame whose enable has just been cleared. It then counts the system clocks of one frame and places the status clear so that it is captured on the exact edge where the raster stops. The status read right afterwards must still show DONE set. A second scenario clears and re-sets the enable bit within one frame, and is judged by the next vsync arriving exactly one frame period later with no DONE raised.

// File: rtl/lcdt_pkg.sv
// Package: register addresses, bit positions, field widths and the packed
// timing-word layout shared by every module of the raster timing generator.
// Assumes a 32-bit register bus with word addresses.
package lcdt_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned ACT_W  = 10;
    localparam int unsigned SW_W   = 6;
    localparam int unsigned PORCH_W = 8;
    localparam int unsigned DIV_W  = 8;
    localparam int unsigned ST_W   = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 3'd0,
        A_HTIM = 3'd1,
        A_VTIM = 3'd2,
        A_CLK  = 3'd3,
        A_STAT = 3'd4
    } reg_addr_e;

    // control word bit positions
    localparam int unsigned C_EN      = 0;
    localparam int unsigned C_TFT     = 1;
    localparam int unsigned C_DONE_M  = 8;
    localparam int unsigned C_FRAME_M = 9;

    // status bit positions
    localparam int unsigned S_DONE  = 0;
    localparam int unsigned S_FRAME = 1;

    // clock word: polarity bits and the mask of storable bits
    localparam int unsigned K_VS_INV = 20;
    localparam int unsigned K_HS_INV = 21;
    localparam logic [DATA_W-1:0] K_MASK = 32'h03F0_FFFF;

    localparam logic [DIV_W-1:0] MIN_DIV_TFT = 8'd2;
    localparam logic [DIV_W-1:0] MIN_DIV_PAS = 8'd3;

    // one packed timing word (same layout for horizontal and vertical)
    typedef struct packed {
        logic [PORCH_W-1:0] bp;
        logic [PORCH_W-1:0] fp;
        logic [SW_W-1:0]    sw;
        logic [ACT_W-1:0]   act;
    } timing_t;

    // divider actually applied after raising it to the mode minimum
    function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d,
                                                 input logic tft);
        logic [DIV_W-1:0] lo;
        lo = tft ? MIN_DIV_TFT : MIN_DIV_PAS;
        return (d < lo) ? lo : d;
    endfunction

endpackage

// File: rtl/lcdt_regs.sv
// Register file: control, two timing words, clock word and status.
// Status bits are write-one-to-clear with set priority; the interrupt is
// the masked OR of status. A control write that drops the enable bit also
// drops the frame-start mask. Assumes single-cycle writes.
module lcdt_regs
    import lcdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              done_evt_i,
    input  logic              frame_evt_i,
    output logic              en_o,
    output logic              tft_o,
    output timing_t           htim_o,
    output timing_t           vtim_o,
    output logic [DIV_W-1:0]  div_o,
    output logic              hs_inv_o,
    output logic              vs_inv_o,
    output logic              done_mask_o,
    output logic              frame_mask_o,
    output logic [ST_W-1:0]   status_o,
    output logic              irq_o
);

    logic [DATA_W-1:0] clkw_q;
    logic              wr_ctrl, wr_stat;
    logic [ST_W-1:0]   st_set, st_clr;

    assign wr_ctrl = wr_en_i && (wr_addr_i == A_CTRL);
    assign wr_stat = wr_en_i && (wr_addr_i == A_STAT);

    // control bits; disabling forces the frame-start mask low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o         <= 1'b0;
            tft_o        <= 1'b0;
            done_mask_o  <= 1'b0;
            frame_mask_o <= 1'b0;
        end else if (wr_ctrl) begin
            en_o         <= wr_data_i[C_EN];
            tft_o        <= wr_data_i[C_TFT];
            done_mask_o  <= wr_data_i[C_DONE_M];
            frame_mask_o <= (en_o && !wr_data_i[C_EN]) ? 1'b0 : wr_data_i[C_FRAME_M];
        end
    end

    // timing and clock words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            htim_o <= '0;
            vtim_o <= '0;
            clkw_q <= '0;
        end else if (wr_en_i) begin
            if (wr_addr_i == A_HTIM) htim_o <= timing_t'(wr_data_i);
            if (wr_addr_i == A_VTIM) vtim_o <= timing_t'(wr_data_i);
            if (wr_addr_i == A_CLK)  clkw_q <= wr_data_i & K_MASK;
        end
    end

    assign div_o    = clkw_q[DIV_W-1:0];
    assign vs_inv_o = clkw_q[K_VS_INV];
    assign hs_inv_o = clkw_q[K_HS_INV];

    assign st_set[S_DONE]  = done_evt_i;
    assign st_set[S_FRAME] = frame_evt_i;
    assign st_clr          = wr_stat ? wr_data_i[ST_W-1:0] : '0;

    // one sticky status flop per bit, set beats clear
    for (genvar i = 0; i < ST_W; i++) begin : g_st
        always_ff @(posedge clk) begin
            if (!rst_n)         status_o[i] <= 1'b0;
            else if (st_set[i]) status_o[i] <= 1'b1;
            else if (st_clr[i]) status_o[i] <= 1'b0;
        end
    end

    assign irq_o = (status_o[S_DONE] && done_mask_o) || (status_o[S_FRAME] && frame_mask_o);

    // read multiplexer
    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            A_CTRL: begin
                rd_data_o[C_EN]      = en_o;
                rd_data_o[C_TFT]     = tft_o;
                rd_data_o[C_DONE_M]  = done_mask_o;
                rd_data_o[C_FRAME_M] = frame_mask_o;
            end
            A_HTIM:  rd_data_o = DATA_W'(htim_o);
            A_VTIM:  rd_data_o = DATA_W'(vtim_o);
            A_CLK:   rd_data_o = clkw_q;
            A_STAT:  rd_data_o[ST_W-1:0] = status_o;
            default: rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/lcdt_pixdiv.sv
// Pixel clock divider: free-running counter that emits a one-clock enable
// every N system clocks, N being the programmed divider raised to the
// minimum of the selected panel mode. Tolerates the divider shrinking
// below the current count by comparing with >=.
module lcdt_pixdiv
    import lcdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             tft_i,
    output logic             tick_o
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;

    assign lim    = eff_div(div_i, tft_i) - ONE;
    assign tick_o = (cnt_q >= lim);

    // count system clocks between pixel enables
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + ONE;
    end

endmodule

// File: rtl/lcdt_raster.sv
// Raster sequencer: pixel and line counters stepped by the pixel enable,
// sync/data-enable decode, and frame-start / done events. The enable input
// is examined only when a frame would begin, so a stop always lands after
// the last pixel of a whole frame. Assumes CNT_W holds the longest frame.
module lcdt_raster
    import lcdt_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             en_i,
    input  timing_t          htim_i,
    input  timing_t          vtim_i,
    input  logic             hs_inv_i,
    input  logic             vs_inv_i,
    output logic             running_o,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             de_o,
    output logic [ACT_W-1:0] pixel_x_o,
    output logic [ACT_W-1:0] line_y_o,
    output logic             done_evt_o,
    output logic             frame_evt_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] h_q, v_q;
    logic [CNT_W-1:0] h_sync_end, h_act_beg, h_act_end, h_last;
    logic [CNT_W-1:0] v_sync_end, v_act_beg, v_act_end, v_last;
    logic             h_end, v_end, hs_act, vs_act, h_in, v_in;

    // segment boundaries from the timing words
    always_comb begin
        h_sync_end = CNT_W'(htim_i.sw) + ONE;
        h_act_beg  = h_sync_end + CNT_W'(htim_i.bp) + ONE;
        h_act_end  = h_act_beg + CNT_W'(htim_i.act) + ONE;
        h_last     = h_act_end + CNT_W'(htim_i.fp);
        v_sync_end = CNT_W'(vtim_i.sw) + ONE;
        v_act_beg  = v_sync_end + CNT_W'(vtim_i.bp);
        v_act_end  = v_act_beg + CNT_W'(vtim_i.act) + ONE;
        v_last     = v_act_end + CNT_W'(vtim_i.fp) - ONE;
    end

    assign h_end = (h_q >= h_last);
    assign v_end = (v_q >= v_last);

    // counter and run-state update on every pixel enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_o <= 1'b0;
            h_q       <= '0;
            v_q       <= '0;
        end else if (tick_i) begin
            if (!running_o) begin
                if (en_i) begin
                    running_o <= 1'b1;
                    h_q       <= '0;
                    v_q       <= '0;
                end
            end else if (h_end) begin
                h_q <= '0;
                if (v_end) begin
                    v_q <= '0;
                    if (!en_i) running_o <= 1'b0;
                end else begin
                    v_q <= v_q + ONE;
                end
            end else begin
                h_q <= h_q + ONE;
            end
        end
    end

    assign frame_evt_o = tick_i && en_i && (!running_o || (h_end && v_end));
    assign done_evt_o  = tick_i && !en_i && running_o && h_end && v_end;

    // output decode from the counters
    always_comb begin
        hs_act    = running_o && (h_q < h_sync_end);
        vs_act    = running_o && (v_q < v_sync_end);
        h_in      = (h_q >= h_act_beg) && (h_q < h_act_end);
        v_in      = (v_q >= v_act_beg) && (v_q < v_act_end);
        de_o      = running_o && h_in && v_in;
        hsync_o   = hs_act ^ hs_inv_i;
        vsync_o   = vs_act ^ vs_inv_i;
        pixel_x_o = de_o ? ACT_W'(h_q - h_act_beg) : '0;
        line_y_o  = de_o ? ACT_W'(v_q - v_act_beg) : '0;
    end

endmodule

// File: rtl/lcd_raster_timer.sv
// Top of the LCD raster timing generator: register file, pixel clock
// divider and raster sequencer. Registers are written and read on the
// system clock; all panel outputs are decoded from registered state.
module lcd_raster_timer
    import lcdt_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              pclk_en_o,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic [ACT_W-1:0]  pixel_x_o,
    output logic [ACT_W-1:0]  line_y_o,
    output logic              tft_o,
    output logic              irq_o
);

    logic             en, tft, hs_inv, vs_inv, done_mask, frame_mask;
    logic             tick, running, done_evt, frame_evt;
    logic [DIV_W-1:0] div;
    logic [ST_W-1:0]  status;
    timing_t          htim, vtim;

    lcdt_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en_i),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i),
        .rd_addr_i    (rd_addr_i),
        .rd_data_o    (rd_data_o),
        .done_evt_i   (done_evt),
        .frame_evt_i  (frame_evt),
        .en_o         (en),
        .tft_o        (tft),
        .htim_o       (htim),
        .vtim_o       (vtim),
        .div_o        (div),
        .hs_inv_o     (hs_inv),
        .vs_inv_o     (vs_inv),
        .done_mask_o  (done_mask),
        .frame_mask_o (frame_mask),
        .status_o     (status),
        .irq_o        (irq_o)
    );

    lcdt_pixdiv u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (div),
        .tft_i  (tft),
        .tick_o (tick)
    );

    lcdt_raster #(.CNT_W(CNT_W)) u_raster (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .en_i        (en),
        .htim_i      (htim),
        .vtim_i      (vtim),
        .hs_inv_i    (hs_inv),
        .vs_inv_i    (vs_inv),
        .running_o   (running),
        .hsync_o     (hsync_o),
        .vsync_o     (vsync_o),
        .de_o        (de_o),
        .pixel_x_o   (pixel_x_o),
        .line_y_o    (line_y_o),
        .done_evt_o  (done_evt),
        .frame_evt_o (frame_evt)
    );

    assign pclk_en_o = tick;
    assign tft_o     = tft;

endmodule

// File: rtl/lcdt_chk.sv
// Checker for the raster timing generator, bound into the top module.
// Observes port outputs and internal control state; reports nothing itself.
module lcdt_chk
    import lcdt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              running,
    input logic              de,
    input logic              hsync,
    input logic              vsync,
    input logic              hs_inv,
    input logic              vs_inv,
    input logic              done_st,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              en_q,
    input logic              frame_mask,
    input logic [ACT_W-1:0]  pixel_x,
    input logic [ACT_W-1:0]  x_max
);

    // R4
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R5
    done_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_st) |-> ($past(running) && !running));

    // R2
    de_no_hsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (hsync == hs_inv));

    // R3
    de_no_vsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (vsync == vs_inv));

    // R6
    mask_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == A_CTRL) && !wr_data[C_EN] && en_q) |=> !frame_mask);

    // R11
    px_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (pixel_x <= x_max));

    // R7
    start_vsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> ((vsync != vs_inv) && (hsync != hs_inv)));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!de && (vsync == vs_inv) && (hsync == hs_inv)));

endmodule

bind lcd_raster_timer lcdt_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (pclk_en_o),
    .running    (running),
    .de         (de_o),
    .hsync      (hsync_o),
    .vsync      (vsync_o),
    .hs_inv     (hs_inv),
    .vs_inv     (vs_inv),
    .done_st    (status[0]),
    .wr_en      (wr_en_i),
    .wr_addr    (wr_addr_i),
    .wr_data    (wr_data_i),
    .en_q       (en),
    .frame_mask (frame_mask),
    .pixel_x    (pixel_x_o),
    .x_max      (htim.act)
);

// File: tb/lcd_raster_timer_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module lcd_raster_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        pclk_en, hsync, vsync, de, tft, irq;
    logic [9:0]  pixel_x, line_y;

    int checks = 0;
    int fails = 0;
    logic inv_h = 1'b0;
    logic inv_v = 1'b0;

    // frame geometry used throughout: 9 ticks per line, 7 lines per frame
    localparam int HTOT = 9;
    localparam int VTOT = 7;
    localparam int FT   = HTOT * VTOT;
    localparam logic [31:0] HWORD = 32'h0100_0403;
    localparam logic [31:0] VWORD = 32'h0201_0002;

    always #10 clk = ~clk;

    lcd_raster_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .pclk_en_o (pclk_en),
        .hsync_o   (hsync),
        .vsync_o   (vsync),
        .de_o      (de),
        .pixel_x_o (pixel_x),
        .line_y_o  (line_y),
        .tft_o     (tft),
        .irq_o     (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    function automatic logic vs_act();
        return vsync ^ inv_v;
    endfunction

    function automatic logic hs_act();
        return hsync ^ inv_h;
    endfunction

    task automatic wait_vs_rise();
        logic p;
        p = 1'b1;
        for (int n = 0; n < 40000; n++) begin
            @(negedge clk);
            if (vs_act() && !p) return;
            p = vs_act();
        end
    endtask

    task automatic measure(output int nclk, output int nde, output int nhs, output int nvs,
                           output int ntick, output int nrise, output int mx, output int my,
                           output int fx, output int fy);
        logic pv, pd;
        nclk = 0; nde = 0; nhs = 0; nvs = 0; ntick = 0; nrise = 0;
        mx = 0; my = 0; fx = -1; fy = -1;
        wait_vs_rise();
        pv = 1'b0; pd = 1'b0;
        for (int n = 0; n < 40000; n++) begin
            if (n != 0) @(negedge clk);
            if (n != 0 && vs_act() && !pv) return;
            nclk++;
            nde   += int'(de);
            nhs   += int'(hs_act());
            nvs   += int'(vs_act());
            ntick += int'(pclk_en);
            if (de && !pd) nrise++;
            if (de) begin
                if (fx < 0) begin fx = int'(pixel_x); fy = int'(line_y); end
                if (int'(pixel_x) > mx) mx = int'(pixel_x);
                if (int'(line_y) > my) my = int'(line_y);
            end
            pv = vs_act(); pd = de;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            chk("R1 register reads zero", d, 0);
        end
        chk("R1 outputs idle", {28'd0, hsync, vsync, de, irq}, 0);
        chk("R12 mode output after reset", {31'd0, tft}, 0);
    endtask

    task automatic t_timing();
        int c, e, h, v, t, r, mx, my, fx, fy;
        logic [31:0] d;
        wr(3'd1, HWORD);
        wr(3'd2, VWORD);
        wr(3'd3, 32'd4);
        wr(3'd0, 32'h203);
        rd(3'd1, d); chk("R2 horizontal word readback", d, HWORD);
        rd(3'd2, d); chk("R3 vertical word readback", d, VWORD);
        chk("R12 mode output TFT", {31'd0, tft}, 1);
        measure(c, e, h, v, t, r, mx, my, fx, fy);
        chk("R4 frame length with divider 4", c, FT * 4);
        chk("R4 pixel enables per frame", t, FT);
        chk("R2 hsync clocks per frame", h, 2 * VTOT * 4);
        chk("R3 vsync clocks per frame", v, 1 * HTOT * 4);
        chk("R2 data-enable clocks per frame", e, 4 * 3 * 4);
        chk("R3 active lines per frame", r, 3);
        chk("R11 last pixel index", mx, 3);
        chk("R11 last line index", my, 2);
        chk("R11 first active position", {fx[15:0], fy[15:0]}, 0);
        rd(3'd4, d); chk("R10 frame-start status", d & 2, 2);
        chk("R9 irq from frame status", {31'd0, irq}, 1);
        wait_vs_rise();
        wr(3'd4, 32'd2);
        rd(3'd4, d); chk("R9 status cleared by write of one", d & 2, 0);
        chk("R9 irq drops after clear", {31'd0, irq}, 0);
    endtask

    task automatic t_divider();
        int c, e, h, v, t, r, mx, my, fx, fy;
        wr(3'd0, 32'h001);
        wr(3'd3, 32'd1);
        measure(c, e, h, v, t, r, mx, my, fx, fy);
        chk("R4 passive divider 1 raised to 3", c, FT * 3);
        chk("R12 mode output passive", {31'd0, tft}, 0);
        wr(3'd0, 32'h003);
        wr(3'd3, 32'd0);
        measure(c, e, h, v, t, r, mx, my, fx, fy);
        chk("R4 TFT divider 0 raised to 2", c, FT * 2);
        wr(3'd3, 32'd255);
        measure(c, e, h, v, t, r, mx, my, fx, fy);
        chk("R4 divider 255", c, FT * 255);
    endtask

    task automatic t_polarity();
        int c, e, h, v, t, r, mx, my, fx, fy;
        logic [31:0] d;
        wr(3'd3, 32'h0330_AB02);
        inv_h = 1'b1; inv_v = 1'b1;
        rd(3'd3, d); chk("R8 clock word readback", d, 32'h0330_AB02);
        measure(c, e, h, v, t, r, mx, my, fx, fy);
        chk("R8 inverted hsync active clocks", h, 2 * VTOT * 2);
        chk("R8 inverted vsync active clocks", v, HTOT * 2);
        chk("R8 frame length unchanged", c, FT * 2);
    endtask

    task automatic t_graceful_stop();
        logic [31:0] d;
        int nde, rises;
        logic pv;
        localparam int F = FT * 2;
        wr(3'd4, 32'd3);
        wr(3'd0, 32'h303);
        wait_vs_rise();
        nde = int'(de); rises = 0; pv = 1'b1;
        for (int k = 1; k <= 2 * F; k++) begin
            @(negedge clk);
            if (k == 5) begin wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'h302; end
            if (k == 6) begin
                wr_en = 1'b0;
                rd(3'd0, d); chk("R6 frame mask dropped, done mask kept", d, 32'h102);
            end
            if (k < F) nde += int'(de);
            if (k == F - 1) begin
                rd(3'd4, d); chk("R5 no DONE before frame end", d & 1, 0);
            end
            if (k == F) begin
                rd(3'd4, d); chk("R5 DONE at frame end", d & 1, 1);
                chk("R9 irq from DONE", {31'd0, irq}, 1);
                chk("R5 outputs idle after stop", {29'd0, hsync, vsync, de}, 3'b110);
            end
            if (k > F && vs_act() && !pv) rises++;
            pv = vs_act();
        end
        chk("R5 stopping frame completes its active pixels", nde, 4 * 3 * 2);
        chk("R5 no further frame after stop", rises, 0);
        wr(3'd4, 32'd3);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        localparam int F = FT * 2;
        wr(3'd0, 32'h103);
        wait_vs_rise();
        chk("R7 start on first vsync line and pixel", {30'd0, vs_act(), hs_act()}, 3);
        for (int k = 1; k <= F; k++) begin
            @(negedge clk);
            if (k == 5) begin wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'h102; end
            if (k == 6) wr_en = 1'b0;
            if (k == F - 1) begin wr_en = 1'b1; wr_addr = 3'd4; wr_data = 32'd1; end
            if (k == F) begin
                wr_en = 1'b0;
                rd(3'd4, d); chk("R9 DONE set wins over same-cycle clear", d & 1, 1);
            end
        end
        wr(3'd4, 32'd3);
        rd(3'd4, d); chk("R9 status clear after collision", d, 0);
        chk("R9 irq low after clear", {31'd0, irq}, 0);
    endtask

    task automatic t_reenable();
        logic [31:0] d;
        logic pv;
        int rise_at;
        localparam int F = FT * 2;
        wr(3'd0, 32'h103);
        wait_vs_rise();
        pv = 1'b1; rise_at = -1;
        for (int k = 1; k <= F + 2; k++) begin
            @(negedge clk);
            if (k == 5)  begin wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'h102; end
            if (k == 6)  wr_en = 1'b0;
            if (k == 20) begin wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'h103; end
            if (k == 21) wr_en = 1'b0;
            if (vs_act() && !pv && rise_at < 0) rise_at = k;
            pv = vs_act();
        end
        chk("R7 next frame follows without gap", rise_at, F);
        rd(3'd4, d); chk("R7 no DONE when re-enabled in-frame", d & 1, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_timing();
        t_divider();
        t_polarity();
        t_graceful_stop();
        t_collision();
        t_reenable();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(150000 * 20);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule